// File: doc/BRIEF.md
# Pulse-Pause Frame Demodulator

This block receives reader-to-tag frames from a one-bit envelope signal. A low level on the envelope is a pause and a high level is carrier. All timing is counted on a tick enable that runs at the 212 kHz subcarrier rate. A bit is measured from the start of one pause to the start of the next, and its value comes from that length. Frames have no length field and no delimiter, so a frame ends only when the timing rules are broken. This usually happens when the reader holds carrier past the longest legal bit.

Every decoded bit is XORed with a keystream bit supplied from outside, and the block pulses an advance strobe so that the keystream source can step. While it waits for a frame, the block also steps the keystream once per idle bit period. When a frame closes, the block gives a one-cycle valid pulse together with the packed frame word, the bit count, an error flag and an end-of-frame timestamp measured in ticks.

Top module: `pulse_pause_rx`

## Requirements
- R1: After reset, frame_valid, ks_advance, frame_err, frame_len, frame_data and frame_end_ts are all zero, and the block is waiting for the first pause of a frame.
- R2: Bit length L is the number of ticks from one pause start to the next. A length from 4 to 17 decodes as 0. A length from 18 to 31 decodes as 1.
- R3: A pause start that comes less than 4 ticks after the previous pause start is a code violation. It ends the frame without adding a bit.
- R4: A code violation ends the frame when the bit reaches an elapsed length of 32 ticks. This applies whether the block is still waiting for carrier to return or is waiting for the next pause. A pause start at exactly 31 ticks is a valid 1.
- R5: frame_len reports the number of decoded bits, saturating at 24. frame_err is 0 exactly when frame_len is between 6 and 23 inclusive.
- R6: Decoded bit i, counted from 0, is stored in frame_data bit i, so the first bit received is the least significant. The stored value is the decoded bit XOR ks_bit, with ks_bit sampled in the tick that decodes that bit. Bits past position 22 are not stored.
- R7: ks_advance pulses for one clock after each decoded bit. No pulse is issued for the pause that starts a frame or for the violation that ends it.
- R8: While waiting for a frame, ks_advance pulses once every 21 ticks. If 40 such periods pass with no pause, the block reports a frame with frame_err=1, frame_len=0 and frame_data=0 at tick 840 after it began waiting, and then waits again.
- R9: The timestamp counts ticks since reset. The timestamp of a tick is the number of earlier ticks. For a frame closed by a violation, frame_end_ts equals the timestamp of the last pause start plus 2.
- R10: frame_valid is high for exactly one clock per frame. The other frame outputs are updated in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Subcarrier-rate enable, one clock wide |
| env_in | input | 1 | Envelope: 0 = pause, 1 = carrier; asynchronous |
| ks_bit | input | 1 | Current keystream bit |
| ks_advance | output | 1 | One-clock strobe asking the keystream to step |
| frame_valid | output | 1 | One-clock frame report strobe |
| frame_data | output | 23 | Decoded frame, first bit in bit 0 |
| frame_len | output | 5 | Number of decoded bits, saturating at 24 |
| frame_err | output | 1 | Frame rejected: bad length or idle timeout |
| frame_end_ts | output | 16 | End-of-frame timestamp in ticks |

## Verification
The assertions check on every cycle that the report strobe lasts one clock and that an accepted frame has a legal length. They also check that an empty report always carries the error flag, that the strobe to the keystream follows a tick, and that the bit timer never passes the 31-tick limit. The bench scenarios are needed for the remaining behaviour. These are the decode threshold at every legal bit length, the short and long violations, the bit packing under the keystream, the 840-tick idle timeout and the timestamp arithmetic. Each of these depends on the sequence of envelope edges and not on any single cycle.

// File: rtl/pprx_pkg.sv
package pprx_pkg;
   typedef enum logic [1:0] {
      RX_HUNT    = 2'd0,
      RX_PAUSE   = 2'd1,
      RX_CARRIER = 2'd2
   } rx_state_e;
endpackage

// File: rtl/pprx_sync.sv
module pprx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial assert (STAGES >= 1) else $error("pprx_sync: STAGES must be at least 1");

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 1'b0;
            else        q <= din;
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], din};
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pprx_edge.sv
module pprx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level,
   output logic fall,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    prev <= 1'b0;
      else if (tick) prev <= level;

   assign fall = tick &  prev & ~level;
   assign rise = tick & ~prev &  level;
endmodule

// File: rtl/pprx_pack.sv
module pprx_pack #(
   parameter int MAX_BITS = 23,
   parameter int LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                push,
   input  logic                bit_in,
   output logic [MAX_BITS-1:0] data,
   output logic [LEN_W-1:0]    len
);
   initial assert ((1 << LEN_W) > MAX_BITS + 1) else $error("pprx_pack: LEN_W too narrow");

   generate
      for (genvar i = 0; i < MAX_BITS; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                          q <= 1'b0;
            else if (clr)                        q <= 1'b0;
            else if (push && len == LEN_W'(i))   q <= bit_in;
         assign data[i] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                    len <= '0;
      else if (clr)                                  len <= '0;
      else if (push && len <= LEN_W'(MAX_BITS))      len <= len + LEN_W'(1);

   AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_W'(MAX_BITS + 1)) else $error("length counter overran"); // R5
endmodule

// File: rtl/pulse_pause_rx.sv
module pulse_pause_rx #(
   parameter int SYNC_STAGES  = 2,
   parameter int PAUSE_T      = 4,
   parameter int BIT0_T       = 13,
   parameter int BIT1_T       = 21,
   parameter int HUNT_PERIODS = 40,
   parameter int MIN_BITS     = 6,
   parameter int MAX_BITS     = 23,
   parameter int PIPE_COMP    = 2,
   parameter int TS_W         = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                env_in,
   input  logic                ks_bit,
   output logic                ks_advance,
   output logic                frame_valid,
   output logic [MAX_BITS-1:0] frame_data,
   output logic [4:0]          frame_len,
   output logic                frame_err,
   output logic [TS_W-1:0]     frame_end_ts
);
   import pprx_pkg::*;

   localparam int THRESH  = (BIT0_T + BIT1_T) / 2;
   localparam int LIMIT   = (BIT1_T * 3) / 2;
   localparam int HUNT_T  = BIT1_T;
   localparam int CNT_W   = $clog2(LIMIT + 2);
   localparam int PC_W    = $clog2(HUNT_T + 1);
   localparam int IDLE_W  = $clog2(HUNT_PERIODS + 1);
   localparam int LEN_W   = 5;
   localparam int END_OFS = PAUSE_T - PIPE_COMP;

   initial begin
      assert (BIT0_T > PAUSE_T && BIT1_T > BIT0_T) else $error("bit lengths out of order");
      assert (PIPE_COMP <= PAUSE_T) else $error("PIPE_COMP exceeds PAUSE_T");
      assert (MIN_BITS >= 1 && MIN_BITS <= MAX_BITS) else $error("bad frame length bounds");
      assert ((1 << LEN_W) > MAX_BITS + 1) else $error("MAX_BITS too large for frame_len");
      assert (HUNT_PERIODS >= 1) else $error("HUNT_PERIODS must be positive");
   end

   // ---------------- front end ----------------
   logic env_s, fall, rise;

   pprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(env_in), .dout(env_s));

   pprx_edge u_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .level(env_s), .fall(fall), .rise(rise));

   // ---------------- state ----------------
   rx_state_e          state;
   logic [CNT_W-1:0]   cnt;
   logic [PC_W-1:0]    pc;
   logic [IDLE_W-1:0]  idle;
   logic [TS_W-1:0]    ts, start_ts;
   logic [LEN_W-1:0]   len;

   logic [CNT_W-1:0] elapsed;
   logic in_frame, late, short_bit, good_bit, hunt_wrap, hunt_fail;
   logic viol, frame_done, bit_val, len_ok;

   always_comb begin
      elapsed   = cnt + CNT_W'(1);
      in_frame  = (state == RX_PAUSE) || (state == RX_CARRIER);
      late      = tick && in_frame && (elapsed > CNT_W'(LIMIT));
      short_bit = fall && (state == RX_CARRIER) && !late && (elapsed < CNT_W'(PAUSE_T));
      good_bit  = fall && (state == RX_CARRIER) && !late && (elapsed >= CNT_W'(PAUSE_T));
      hunt_wrap = tick && (state == RX_HUNT) && !fall && (pc == PC_W'(HUNT_T - 1));
      hunt_fail = hunt_wrap && (idle == IDLE_W'(HUNT_PERIODS - 1));
      viol      = late || short_bit;
      frame_done = viol || hunt_fail;
      bit_val   = elapsed > CNT_W'(THRESH);
      len_ok    = (len >= LEN_W'(MIN_BITS)) && (len <= LEN_W'(MAX_BITS));
   end

   pprx_pack #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .clr((fall && state == RX_HUNT) || hunt_fail),
      .push(good_bit), .bit_in(bit_val ^ ks_bit),
      .data(frame_data), .len(len));

   assign frame_len = len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= RX_HUNT;
         cnt          <= '0;
         pc           <= '0;
         idle         <= '0;
         ts           <= '0;
         start_ts     <= '0;
         frame_valid  <= 1'b0;
         frame_err    <= 1'b0;
         frame_end_ts <= '0;
         ks_advance   <= 1'b0;
      end else begin
         frame_valid <= frame_done;
         ks_advance  <= hunt_wrap || good_bit;
         if (frame_done) begin
            frame_err    <= hunt_fail || !len_ok;
            frame_end_ts <= hunt_fail ? ts : start_ts + TS_W'(END_OFS);
         end
         if (tick) begin
            ts <= ts + TS_W'(1);
            unique case (state)
               RX_HUNT: begin
                  if (fall) begin
                     state    <= RX_PAUSE;
                     cnt      <= '0;
                     start_ts <= ts;
                  end else if (hunt_wrap) begin
                     pc   <= '0;
                     idle <= hunt_fail ? '0 : idle + IDLE_W'(1);
                  end else begin
                     pc <= pc + PC_W'(1);
                  end
               end
               RX_PAUSE: begin
                  if (late) begin
                     state <= RX_HUNT; cnt <= '0; pc <= '0; idle <= '0;
                  end else begin
                     if (rise) state <= RX_CARRIER;
                     cnt <= elapsed;
                  end
               end
               RX_CARRIER: begin
                  if (viol) begin
                     state <= RX_HUNT; cnt <= '0; pc <= '0; idle <= '0;
                  end else if (fall) begin
                     state    <= RX_PAUSE;
                     cnt      <= '0;
                     start_ts <= ts;
                  end else begin
                     cnt <= elapsed;
                  end
               end
               default: state <= RX_HUNT;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid) else $error("frame_valid longer than one clock"); // R10
   AST_ACCEPTED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !frame_err) |-> (frame_len >= 5'(MIN_BITS) && frame_len <= 5'(MAX_BITS)))
      else $error("accepted frame with illegal length"); // R5
   AST_EMPTY_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_len == 5'd0) |-> frame_err) else $error("empty frame without error"); // R8
   AST_ADVANCE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ks_advance |-> $past(tick)) else $error("advance without tick"); // R7
   AST_TIMER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state != RX_HUNT) |-> (cnt <= CNT_W'(LIMIT))) else $error("bit timer past limit"); // R4
   AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idle < IDLE_W'(HUNT_PERIODS)) else $error("idle period count overran"); // R8
endmodule

// File: tb/pulse_pause_rx_bench.sv
module pulse_pause_rx_bench;
   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, env_in = 1'b1, ks_bit;
   logic ks_advance, frame_valid, frame_err;
   logic [22:0] frame_data;
   logic [4:0]  frame_len;
   logic [15:0] frame_end_ts;

   pulse_pause_rx u_pulse_pause_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .env_in(env_in), .ks_bit(ks_bit),
      .ks_advance(ks_advance), .frame_valid(frame_valid), .frame_data(frame_data),
      .frame_len(frame_len), .frame_err(frame_err), .frame_end_ts(frame_end_ts));

   always #5 clk = ~clk;

   logic [1:0] tdiv = 2'd0;
   always @(negedge clk) begin
      tdiv <= tdiv + 2'd1;
      tick <= (tdiv == 2'd2);
   end

   int tk = 0;
   always @(posedge clk) if (rst_n && tick) tk <= tk + 1;

   logic [15:0] lfsr;
   always @(posedge clk)
      if (!rst_n) lfsr <= 16'hACE1;
      else if (ks_advance) lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
   assign ks_bit = lfsr[0];

   int adv_cnt = 0, nframes = 0, dbl_valid = 0, cap_tk = 0, cap_adv = 0;
   logic prev_valid = 1'b0, cap_err = 1'b0;
   logic [22:0] cap_data = '0;
   logic [4:0]  cap_len = '0;
   logic [15:0] cap_ts = '0;
   always @(negedge clk) begin
      adv_cnt    <= adv_cnt + int'(ks_advance);
      prev_valid <= frame_valid;
      if (frame_valid && prev_valid) dbl_valid <= dbl_valid + 1;
      if (frame_valid) begin
         nframes  <= nframes + 1;
         cap_data <= frame_data;
         cap_len  <= frame_len;
         cap_err  <= frame_err;
         cap_ts   <= frame_end_ts;
         cap_tk   <= tk;
         cap_adv  <= adv_cnt + int'(ks_advance);
      end
   end

   int checks = 0, fails = 0;
   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick_step();
      @(posedge clk);
      while (!tick) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) tick_step();
   endtask

   int   blen[0:31];
   int   kstart[0:32];
   logic kss[0:31];

   // Sends blen[0..n-1], then a final pause held 'tail' ticks and 40 ticks of carrier.
   task automatic run_frame(input int n, input int tail, input string req);
      int base_frames, adv_base, dec, exp_len, exp_ts;
      logic [22:0] exp_data;
      base_frames = nframes;
      adv_base    = adv_cnt;
      for (int i = 0; i < n; i++) begin
         int p;
         if (i > 0) kss[i-1] = lfsr[0];
         env_in    = 1'b0;
         kstart[i] = tk;
         p = (blen[i] > 4) ? 4 : blen[i] - 1;
         steps(p);
         env_in = 1'b1;
         steps(blen[i] - p);
      end
      if (n > 0) kss[n-1] = lfsr[0];
      env_in    = 1'b0;
      kstart[n] = tk;
      steps(tail);
      env_in = 1'b1;
      steps(40);
      // expected values from the requirements
      dec = n;
      for (int i = n - 1; i >= 0; i--) if (blen[i] < 4 || blen[i] > 31) dec = i;
      exp_len  = (dec > 24) ? 24 : dec;
      exp_ts   = kstart[dec] + 2;
      exp_data = '0;
      for (int i = 0; i < dec && i < 23; i++) exp_data[i] = (blen[i] > 17) ^ kss[i];
      check(req, "frames reported (R10)", nframes - base_frames, 1);
      check(req, "frame_len (R5)", cap_len, exp_len);
      check(req, "frame_err (R5)", cap_err, (exp_len >= 6 && exp_len <= 23) ? 0 : 1);
      check(req, "frame_data (R2/R6)", cap_data, exp_data);
      check(req, "frame_end_ts (R9)", cap_ts, exp_ts & 16'hFFFF);
      check(req, "advances in frame (R7)", cap_adv - adv_base, dec);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [19:0] pat;
      repeat (5) @(negedge clk);
      // R1 reset state
      check("R1", "frame_valid", frame_valid, 0);
      check("R1", "ks_advance", ks_advance, 0);
      check("R1", "frame_len", frame_len, 0);
      check("R1", "frame_err", frame_err, 0);
      check("R1", "frame_data", frame_data, 0);
      check("R1", "frame_end_ts", frame_end_ts, 0);
      rst_n = 1'b1;

      // R8 idle timeout with carrier held
      while (nframes == 0 && tk < 2000) tick_step();
      check("R8", "timeout frames", nframes, 1);
      check("R8", "timeout tick", cap_tk, 840);
      check("R8", "timeout advances", cap_adv, 40);
      check("R8", "timeout err", cap_err, 1);
      check("R8", "timeout len", cap_len, 0);
      check("R8", "timeout data", cap_data, 0);

      // R2 sweep of every legal bit length
      for (int l = 4; l <= 31; l++) begin
         for (int i = 0; i < 6; i++) blen[i] = l;
         run_frame(6, 8, "R2");
      end

      // R6 mixed patterns, first bit least significant
      pat = 20'h00A5C;
      for (int i = 0; i < 12; i++) blen[i] = pat[i] ? 21 : 13;
      run_frame(12, 8, "R6");
      pat = 20'h3C96A;
      for (int i = 0; i < 20; i++) blen[i] = pat[i] ? ((i % 2) ? 18 : 31) : ((i % 2) ? 17 : 4);
      run_frame(20, 8, "R6");

      // R5 every frame length from 1 to 25
      for (int n = 1; n <= 25; n++) begin
         for (int i = 0; i < n; i++) blen[i] = (i % 3 == 0) ? 21 : 13;
         run_frame(n, 8, "R5");
      end

      // R3 short bit ends frame
      for (int i = 0; i < 7; i++) blen[i] = (i % 2) ? 21 : 13;
      blen[7] = 3;
      run_frame(8, 4, "R3");
      blen[0] = 21; blen[1] = 13; blen[2] = 2;
      run_frame(3, 4, "R3");

      // R4 final pause held 32 and 31 ticks
      for (int i = 0; i < 7; i++) blen[i] = (i % 2) ? 13 : 21;
      run_frame(7, 32, "R4");
      run_frame(7, 31, "R4");

      check("R10", "double-width valid pulses", dbl_valid, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule